// File: doc/BRIEF.md
# Proximity-Gated Serial Code Lock

This block releases a lock once a user standing near it keys in a fixed five-symbol binary code on two push buttons. One button enters the symbol 1 and the other enters the symbol 0. Each raw button level passes through a synchronizer and an edge detector, so one press gives exactly one symbol, however long the button is held. A small control FSM compares every symbol against the expected symbol for the current position. After the fifth correct symbol it raises the unlock output.

A level input from an external distance sensor gates the block. While that input shows nobody near, presses are dropped, any partly entered code is discarded and an open lock closes again. Any wrong symbol, including both buttons arriving in the same cycle, sends the entry back to the first position. The symbol that was wrong is used up and does not start a new attempt.

Top module: `codelock_top`

## Requirements
- R1: The code is the symbol sequence 1, 0, 1, 0, 0, entered first symbol first. Once the whole sequence has been accepted, `unlock` reads 1 and it reads 0 before that.
- R2: A press on `btnOne` enters the symbol 1 and a press on `btnZero` enters the symbol 0.
- R3: Each button is synchronized through two flops and then edge-detected. A rising edge gives one internal pulse of one cycle, so holding a button enters a single symbol. When the final correct symbol is driven high just after a clock edge, `unlock` is still 0 after the second following rising edge and is 1 after the third.
- R4: While `presentIn` is 0, button presses are not accepted. A complete correct sequence pressed while absent leaves `unlock` at 0.
- R5: A wrong symbol at any position returns the entry to the first position with no partial match. The wrong symbol does not count as the start of a new entry.
- R6: A 1 pulse and a 0 pulse in the same cycle count as a wrong symbol.
- R7: Once `unlock` is 1, it stays 1 while `presentIn` stays 1, whatever buttons are then pressed.
- R8: When `presentIn` is 0 at a clock edge, `unlock` is 0 after that edge and any partly entered code is discarded.
- R9: Synchronous active-high `rst` sets `unlock` to 0 and discards any partial entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btnOne | input | 1 | Raw push button that enters the symbol 1 |
| btnZero | input | 1 | Raw push button that enters the symbol 0 |
| presentIn | input | 1 | User-near flag from the distance sensor, already in the clock domain |
| unlock | output | 1 | High while the lock is released |

## Verification
The assertions assume that `presentIn` is already synchronous to `clk`. The stimulus changes it only on falling clock edges. The one-cycle pulse and the same-cycle collision checks also assume that buttons do not bounce. The bench drives each press as one clean high period of several cycles, followed by a low period long enough for the edge detector to rearm. The only same-cycle collision it drives is the deliberate two-button press.

// File: rtl/codelock_pkg.sv
package codelock_pkg;

  typedef struct packed {
    logic clrPos;
    logic incPos;
    logic setOpen;
    logic clrOpen;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTRY = 2'd1,
    ST_OPEN  = 2'd2
  } lock_state_t;

endpackage

// File: rtl/codelock_btnpulse.sv
module codelock_btnpulse #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic pulseOut
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] syncQ;
  logic         lastQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[TOP-1:0], rawIn};
      lastQ <= syncQ[TOP];
    end
  end

  assign pulseOut = syncQ[TOP] & ~lastQ;

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pulseOut |=> !pulseOut);

endmodule

// File: rtl/codelock_dp.sv
module codelock_dp
  import codelock_pkg::*;
#(
  parameter int                CODE_LEN = 5,
  parameter logic [CODE_LEN-1:0] CODE   = 5'b10100
) (
  input  logic    clk,
  input  logic    rst,
  input  strobe_t stb,
  input  logic    pulseOne,
  input  logic    pulseZero,
  output logic    symOk,
  output logic    atLast,
  output logic    unlockQ
);

  localparam int POS_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;

  logic [POS_W-1:0] posQ;
  logic             expectBit;

  always_comb begin
    expectBit = 1'b0;
    for (int i = 0; i < CODE_LEN; i++) begin
      if (posQ == POS_W'(i)) expectBit = CODE[CODE_LEN-1-i];
    end
  end

  assign symOk  = (pulseOne ^ pulseZero) && (pulseOne == expectBit);
  assign atLast = (posQ == POS_W'(CODE_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      posQ    <= '0;
      unlockQ <= 1'b0;
    end else begin
      if (stb.clrPos)      posQ <= '0;
      else if (stb.incPos) posQ <= posQ + 1'b1;
      if (stb.clrOpen)      unlockQ <= 1'b0;
      else if (stb.setOpen) unlockQ <= 1'b1;
    end
  end

  // R5
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    posQ < POS_W'(CODE_LEN));

  // R1
  open_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlockQ) |-> $past(symOk && atLast));

endmodule

// File: rtl/codelock_ctrl.sv
module codelock_ctrl
  import codelock_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    presentIn,
  input  logic    pulseOne,
  input  logic    pulseZero,
  input  logic    symOk,
  input  logic    atLast,
  output strobe_t stb
);

  lock_state_t stateQ, stateD;
  logic        anyPulse;

  assign anyPulse = pulseOne | pulseZero;

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    if (!presentIn) begin
      stb.clrPos  = 1'b1;
      stb.clrOpen = 1'b1;
      stateD      = ST_IDLE;
    end else if (stateQ != ST_OPEN && anyPulse) begin
      if (symOk && atLast) begin
        stb.setOpen = 1'b1;
        stb.clrPos  = 1'b1;
        stateD      = ST_OPEN;
      end else if (symOk) begin
        stb.incPos = 1'b1;
        stateD     = ST_ENTRY;
      end else begin
        stb.clrPos = 1'b1;
        stateD     = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  // R8
  absent_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !presentIn |=> stateQ == ST_IDLE);

  // R6
  collision_chk: assert property (@(posedge clk) disable iff (rst)
    (presentIn && pulseOne && pulseZero && stateQ != ST_OPEN) |=> stateQ == ST_IDLE);

  // R7
  open_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_OPEN && presentIn) |=> stateQ == ST_OPEN);

  // R4
  absent_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!presentIn && stateQ == ST_IDLE) |=> stateQ == ST_IDLE);

endmodule

// File: rtl/codelock_top.sv
module codelock_top
  import codelock_pkg::*;
#(
  parameter int                  CODE_LEN    = 5,
  parameter logic [CODE_LEN-1:0] CODE        = 5'b10100,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btnOne,
  input  logic btnZero,
  input  logic presentIn,
  output logic unlock
);

  localparam int NUM_BTNS = 2;

  logic [NUM_BTNS-1:0] rawBtn;
  logic [NUM_BTNS-1:0] btnPulse;
  strobe_t             stb;
  logic                symOk;
  logic                atLast;

  assign rawBtn = {btnOne, btnZero};

  for (genvar b = 0; b < NUM_BTNS; b++) begin : g_btn
    codelock_btnpulse #(.SYNC_STAGES(SYNC_STAGES)) u_pulse (
      .clk      (clk),
      .rst      (rst),
      .rawIn    (rawBtn[b]),
      .pulseOut (btnPulse[b])
    );
  end

  codelock_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .presentIn (presentIn),
    .pulseOne  (btnPulse[1]),
    .pulseZero (btnPulse[0]),
    .symOk     (symOk),
    .atLast    (atLast),
    .stb       (stb)
  );

  codelock_dp #(.CODE_LEN(CODE_LEN), .CODE(CODE)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .pulseOne  (btnPulse[1]),
    .pulseZero (btnPulse[0]),
    .symOk     (symOk),
    .atLast    (atLast),
    .unlockQ   (unlock)
  );

  // R8
  absent_closed_chk: assert property (@(posedge clk) disable iff (rst)
    !presentIn |=> !unlock);

  // R7
  unlock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (unlock && presentIn) |=> unlock);

endmodule

// File: tb/codelock_top_test.sv
module codelock_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;
  localparam int HOLD       = 3;
  localparam int GAP        = 5;

  // Row = {op[1:0], present, expected unlock}; op 0 none, 1 one, 2 zero, 3 both
  localparam int N_STEPS = 47;
  localparam logic [3:0] STEPS [N_STEPS] = '{
    // R1 R2: 1,0,1,0,0 opens
    4'b0110, 4'b1010, 4'b0110, 4'b1010, 4'b1011,
    // R7: presses while open change nothing
    4'b0111, 4'b1011,
    // R8: absence closes
    4'b0000, 4'b0010,
    // R5: 1,1,0,1,0,0 no partial match
    4'b0110, 4'b0110, 4'b1010, 4'b0110, 4'b1010, 4'b1010,
    4'b0110, 4'b1010, 4'b0110, 4'b1010, 4'b1011,
    4'b0000, 4'b0010,
    // R6: 1,0,both,1,0,0 then full code
    4'b0110, 4'b1010, 4'b1110, 4'b0110, 4'b1010, 4'b1010,
    4'b0110, 4'b1010, 4'b0110, 4'b1010, 4'b1011,
    // R4: full code while absent
    4'b0000,
    4'b0100, 4'b1000, 4'b0100, 4'b1000, 4'b1000,
    // R8: 1,0,1 then absence then 0,0
    4'b0010,
    4'b0110, 4'b1010, 4'b0110, 4'b0000, 4'b0010, 4'b1010, 4'b1010
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnOne = 1'b0;
  logic btnZero = 1'b0;
  logic presentIn = 1'b0;
  logic unlock;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  codelock_top uut (
    .clk       (clk),
    .rst       (rst),
    .btnOne    (btnOne),
    .btnZero   (btnZero),
    .presentIn (presentIn),
    .unlock    (unlock)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tagFor(int idx);
    if (idx < 5)  return "R1/R2";
    if (idx < 7)  return "R7";
    if (idx < 9)  return "R8";
    if (idx < 22) return "R5";
    if (idx < 33) return "R6";
    if (idx < 40) return "R4";
    return "R8";
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: unlock=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic press(int op, int holdCycles);
    @(negedge clk);
    btnOne  = (op == 1 || op == 3);
    btnZero = (op == 2 || op == 3);
    idle(holdCycles);
    btnOne  = 1'b0;
    btnZero = 1'b0;
    idle(GAP);
  endtask

  task automatic enter(logic [4:0] syms, int n);
    for (int i = n - 1; i >= 0; i--) press(syms[i] ? 1 : 2, HOLD);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R9 reset state", unlock, 1'b0);
    rst = 1'b0;
    presentIn = 1'b1;
    idle(2);

    for (int s = 0; s < N_STEPS; s++) begin
      @(negedge clk);
      presentIn = STEPS[s][1];
      if (STEPS[s][3:2] == 2'd0) idle(GAP + HOLD);
      else press(int'(STEPS[s][3:2]), HOLD);
      check(tagFor(s), unlock, STEPS[s][0]);
    end

    // R3: a long hold enters one symbol only
    presentIn = 1'b0;
    idle(2);
    presentIn = 1'b1;
    press(1, 20);
    check("R3 long hold", unlock, 1'b0);
    enter(5'b00100, 4);
    check("R3 long hold one symbol", unlock, 1'b1);

    // R3: latency of the final symbol
    presentIn = 1'b0;
    idle(2);
    presentIn = 1'b1;
    enter(5'b01010, 4);
    btnZero = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R3 latency two edges", unlock, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R3 latency three edges", unlock, 1'b1);
    btnZero = 1'b0;
    idle(GAP);

    // R9: reset closes an open lock
    doReset();
    check("R9 reset while open", unlock, 1'b0);

    // R9: reset discards a partial entry
    enter(5'b00101, 3);
    doReset();
    enter(5'b00000, 2);
    check("R9 reset mid entry", unlock, 1'b0);
    enter(5'b10100, 5);
    check("R9 code after reset", unlock, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule